// File: doc/BRIEF.md
# Digital Loss-of-Signal Detector

This block sits after a clock and data recovery stage on a bipolar line. Each line clock cycle it receives one bit period, marked by a positive-pulse flag, a negative-pulse flag, or neither for a zero. It declares loss of signal when too many bit periods in a row carry no pulse. It withdraws the declaration only after a long stretch of bit periods in which no excessive-zero event occurs. The zero run that counts as excessive depends on the selected line code.

An analog loss flag from an external level detector takes part in both decisions. While the flag is high, the recovered pulses are muted, so the digital logic sees only zeros. Recovery counting cannot start until the flag drops. The LOS output is high whenever either the digital detector or the analog flag is active. The digital path declares loss much sooner than the slow analog path, so on a dead line it is normally the digital side that raises LOS first.

The line delivers one bit period on every clock cycle and cannot be paused. For that reason there is no valid/ready handshake and no back-pressure. All pins are plain, sampled on every rising clock edge.

Top module: `los_monitor`

## Requirements
- R1: After reset, `los_o` is 1, and both the zero-run count and the clear count start at zero.
- R2: `mute_o` equals `aloss_i`. While `aloss_i` is 1, pulse flags are treated as zeros.
- R3: With the digital detector clear, `los_o` rises at the edge that samples the DECL_N-th consecutive zero bit period (default 175). A run of only DECL_N-1 zeros does not raise it.
- R4: A pulse on either `pulse_pos_i` or `pulse_neg_i` while `aloss_i` is 0 restarts the zero run.
- R5: While digital loss is set and `aloss_i` is 0, the digital detector clears at the edge that samples the CLR_N-th consecutive bit period without an excessive-zero event (default 175).
- R6: An excessive-zero event is a zero run reaching 3 when `code_sel_i` is 0 (B3ZS) or 4 when `code_sel_i` is 1 (HDB3). Such an event restarts the clear count.
- R7: While `aloss_i` is 1, the digital detector cannot clear, and the clear count is held at zero.
- R8: `los_o` is the OR of the digital loss state and `aloss_i`.
- R9: The zero-run count saturates and does not wrap, so an arbitrarily long zero run keeps loss declared.
- R10: DECL_N and CLR_N are parameters. Elaboration fails if either lies outside 10 to 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Recovered line clock, one bit period per cycle |
| rst_ni | input | 1 | Active-low synchronous reset |
| pulse_pos_i | input | 1 | Positive-polarity pulse in this bit period |
| pulse_neg_i | input | 1 | Negative-polarity pulse in this bit period |
| aloss_i | input | 1 | Analog level detector reports loss |
| code_sel_i | input | 1 | Line code: 0 = B3ZS, 1 = HDB3 |
| los_o | output | 1 | Loss of signal, digital or analog |
| mute_o | output | 1 | Recovered data is being muted |

## Verification
The bound checker checks the following on every cycle:
- a pulse empties the zero run;
- a saturated run stays saturated;
- digital loss cannot fall while the analog flag is high;
- any rise of digital loss is preceded by a full zero run;
- any fall is preceded by a full clear count;
- an excessive-zero event zeroes the clear count.

Some behaviours only the bench scenarios can show:
- the exact cycle counts at the thresholds;
- the difference between the two line codes on a 1000 repeating pattern;
- a near-miss run of DECL_N-1 zeros;
- combined outputs under random analog bursts.

// File: rtl/los_pkg.sv
package los_pkg;

  localparam int unsigned LOS_CW = 8;

  typedef enum logic {
    CODE_B3ZS = 1'b0,
    CODE_HDB3 = 1'b1
  } line_code_e;

  // shortest zero run that counts as excessive for each line code
  function automatic logic [LOS_CW-1:0] exz_len(line_code_e code);
    return (code == CODE_HDB3) ? LOS_CW'(4) : LOS_CW'(3);
  endfunction

endpackage

// File: rtl/los_zero_run.sv
module los_zero_run
  import los_pkg::*;
#(
  parameter int unsigned CW = LOS_CW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pulse_i,
  input  line_code_e    code_i,
  output logic [CW-1:0] run_q,
  output logic [CW-1:0] run_nxt,
  output logic          exc_o
);

  localparam logic [CW-1:0] RUN_MAX = {CW{1'b1}};

  always_comb begin
    if (pulse_i)              run_nxt = '0;
    else if (run_q == RUN_MAX) run_nxt = run_q;
    else                      run_nxt = run_q + 1'b1;
  end

  assign exc_o = !pulse_i && (run_nxt >= CW'(exz_len(code_i)));

  always_ff @(posedge clk_i) begin
    if (!rst_ni) run_q <= '0;
    else         run_q <= run_nxt;
  end

endmodule

// File: rtl/los_clear_qual.sv
module los_clear_qual #(
  parameter int unsigned CW    = 8,
  parameter int unsigned CLR_N = 175
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arm_i,
  input  logic          exc_i,
  output logic [CW-1:0] cnt_q,
  output logic          done_o
);

  logic [CW:0] cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign done_o  = arm_i && !exc_i && (cnt_inc >= (CW+1)'(CLR_N));

  always_ff @(posedge clk_i) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (!arm_i || exc_i || done_o) cnt_q <= '0;
    else                            cnt_q <= cnt_inc[CW-1:0];
  end

endmodule

// File: rtl/los_state.sv
module los_state #(
  parameter int unsigned CW     = 8,
  parameter int unsigned DECL_N = 175
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] run_nxt_i,
  input  logic          done_i,
  output logic          dlos_q
);

  logic declare;

  assign declare = !dlos_q && (run_nxt_i >= CW'(DECL_N));

  always_ff @(posedge clk_i) begin
    if (!rst_ni)               dlos_q <= 1'b1;
    else if (declare)          dlos_q <= 1'b1;
    else if (dlos_q && done_i) dlos_q <= 1'b0;
  end

endmodule

// File: rtl/los_monitor.sv
module los_monitor
  import los_pkg::*;
#(
  parameter int unsigned DECL_N = 175,
  parameter int unsigned CLR_N  = 175
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_pos_i,
  input  logic pulse_neg_i,
  input  logic aloss_i,
  input  logic code_sel_i,
  output logic los_o,
  output logic mute_o
);

  localparam int unsigned CW = LOS_CW;

  // R10 threshold range checks
  if (DECL_N < 10 || DECL_N > 255) begin : g_bad_decl
    $error("DECL_N out of range 10..255");
  end
  if (CLR_N < 10 || CLR_N > 255) begin : g_bad_clr
    $error("CLR_N out of range 10..255");
  end

  logic          pulse;
  logic [CW-1:0] run_q;
  logic [CW-1:0] run_nxt;
  logic          exc;
  logic [CW-1:0] clr_cnt;
  logic          clr_done;
  logic          dlos_q;
  logic          arm;

  // muting: analog loss masks recovered pulses
  assign pulse  = (pulse_pos_i | pulse_neg_i) & ~aloss_i;
  assign mute_o = aloss_i;
  assign arm    = dlos_q & ~aloss_i;

  los_zero_run #(.CW(CW)) u_run (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pulse_i (pulse),
    .code_i  (line_code_e'(code_sel_i)),
    .run_q   (run_q),
    .run_nxt (run_nxt),
    .exc_o   (exc)
  );

  los_clear_qual #(.CW(CW), .CLR_N(CLR_N)) u_clr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (arm),
    .exc_i  (exc),
    .cnt_q  (clr_cnt),
    .done_o (clr_done)
  );

  los_state #(.CW(CW), .DECL_N(DECL_N)) u_state (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_nxt_i (run_nxt),
    .done_i    (clr_done),
    .dlos_q    (dlos_q)
  );

  assign los_o = dlos_q | aloss_i;

endmodule

// File: rtl/los_monitor_chk.sv
module los_monitor_chk #(
  parameter int unsigned CW     = 8,
  parameter int unsigned DECL_N = 175,
  parameter int unsigned CLR_N  = 175
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          pulse_pos_i,
  input logic          pulse_neg_i,
  input logic          aloss_i,
  input logic          dlos_i,
  input logic          exc_i,
  input logic [CW-1:0] run_i,
  input logic [CW-1:0] cnt_i
);

  localparam logic [CW-1:0] RUN_MAX = {CW{1'b1}};

  AST_PULSE_EMPTIES_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pulse_pos_i || pulse_neg_i) && !aloss_i) |=> (run_i == '0)); // R4

  AST_RUN_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i == RUN_MAX && !pulse_pos_i && !pulse_neg_i) |=> (run_i == RUN_MAX)); // R9

  AST_ALOSS_HOLDS_LOSS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aloss_i && dlos_i) |=> dlos_i); // R7

  AST_RISE_AFTER_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dlos_i) |-> ($past(run_i) >= CW'(DECL_N - 1))); // R3

  AST_FALL_AFTER_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dlos_i) |-> ($past(cnt_i) == CW'(CLR_N - 1))); // R5

  AST_EXCESS_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_i && dlos_i) |=> (cnt_i == '0)); // R6

endmodule

bind los_monitor los_monitor_chk #(
  .CW(CW), .DECL_N(DECL_N), .CLR_N(CLR_N)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pulse_pos_i (pulse_pos_i),
  .pulse_neg_i (pulse_neg_i),
  .aloss_i     (aloss_i),
  .dlos_i      (dlos_q),
  .exc_i       (exc),
  .run_i       (run_q),
  .cnt_i       (clr_cnt)
);

// File: tb/los_monitor_tb.sv
module los_monitor_tb_top;

  localparam int DECL_N = 175;
  localparam int CLR_N  = 175;
  localparam int WATCHDOG_CYC = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pos_i = 1'b0, neg_i = 1'b0, al_i = 1'b0, code_i = 1'b0;
  logic los_o, mute_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  // reference model state
  int  zr_m = 0, cc_m = 0;
  bit  dl_m = 1'b1;

  always #10 clk = ~clk;

  los_monitor #(.DECL_N(DECL_N), .CLR_N(CLR_N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pulse_pos_i(pos_i), .pulse_neg_i(neg_i),
    .aloss_i(al_i), .code_sel_i(code_i), .los_o(los_o), .mute_o(mute_o)
  );

  function automatic int exz(bit c);
    return c ? 4 : 3;
  endfunction

  // advance the model by one bit period with the inputs currently applied
  function automatic void model_step();
    bit pulse, exc;
    pulse = (pos_i | neg_i) & ~al_i;
    if (pulse) zr_m = 0;
    else if (zr_m < 255) zr_m++;
    exc = !pulse && (zr_m >= exz(code_i));
    if (!dl_m) begin
      cc_m = 0;
      if (zr_m >= DECL_N) dl_m = 1'b1;
    end else if (al_i || exc) begin
      cc_m = 0;
    end else if (cc_m + 1 >= CLR_N) begin
      dl_m = 1'b0;
      cc_m = 0;
    end else begin
      cc_m++;
    end
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input bit p, input bit n, input bit a, input bit c, input string req);
    @(negedge clk);
    model_step();
    check(los_o == (dl_m | al_i), req, "los_o", los_o, dl_m | al_i);
    check(mute_o == al_i, "R2", "mute_o", mute_o, al_i);
    pos_i = p; neg_i = n; al_i = a; code_i = c;
  endtask

  task automatic zeros(input int k, input bit c, input string req);
    for (int i = 0; i < k; i++) tick(1'b0, 1'b0, 1'b0, c, req);
  endtask

  task automatic pattern(input int k, input int period, input bit c, input string req);
    for (int i = 0; i < k; i++) begin
      bit one;
      one = (i % period) == 0;
      tick(one & i[0], one & ~i[0], 1'b0, c, req);
    end
  endtask

  initial begin
    #(WATCHDOG_CYC * 20);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd12345;
    void'($urandom(seed));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    check(los_o == 1'b1, "R1", "los_o after reset", los_o, 1);
    check(mute_o == 1'b0, "R2", "mute_o after reset", mute_o, 0);

    // R5: clean alternating marks clear loss after exactly CLR_N periods
    pattern(CLR_N, 1, 1'b0, "R5");
    @(negedge clk); model_step();
    check(los_o == 1'b0, "R5", "los_o after CLR_N marks", los_o, 0);
    pos_i = 1'b0; neg_i = 1'b0;

    // R4/R3: near-miss run then full run
    zeros(DECL_N - 2, 1'b0, "R3");
    tick(1'b1, 1'b0, 1'b0, 1'b0, "R3");
    tick(1'b0, 1'b0, 1'b0, 1'b0, "R4");
    check(los_o == 1'b0, "R4", "los_o after DECL_N-1 zeros and a pulse", los_o, 0);
    zeros(DECL_N, 1'b0, "R3");
    check(los_o == 1'b1, "R3", "los_o after DECL_N zeros", los_o, 1);

    // R7: analog loss blocks recovery even with clean marks
    for (int i = 0; i < 300; i++) tick(i[0], ~i[0], 1'b1, 1'b0, "R7");
    check(los_o == 1'b1, "R7", "los_o during analog loss", los_o, 1);
    pattern(CLR_N + 2, 1, 1'b0, "R7");
    check(los_o == 1'b0, "R7", "los_o after analog loss drops", los_o, 0);

    // R6: pattern 1000 clears in HDB3 but not in B3ZS
    zeros(DECL_N + 1, 1'b1, "R6");
    pattern(400, 4, 1'b1, "R6");
    check(los_o == 1'b0, "R6", "los_o HDB3 1000", los_o, 0);
    zeros(DECL_N + 1, 1'b0, "R6");
    pattern(400, 4, 1'b0, "R6");
    check(los_o == 1'b1, "R6", "los_o B3ZS 1000", los_o, 1);
    pattern(400, 3, 1'b0, "R6");
    check(los_o == 1'b0, "R6", "los_o B3ZS 100", los_o, 0);

    // R9: very long zero run keeps loss
    zeros(700, 1'b0, "R9");
    check(los_o == 1'b1, "R9", "los_o after 700 zeros", los_o, 1);
    pattern(CLR_N + 2, 2, 1'b0, "R9");

    // R8: single-cycle analog flag while digital is clear
    tick(1'b1, 1'b0, 1'b1, 1'b0, "R8");
    tick(1'b0, 1'b1, 1'b0, 1'b0, "R8");
    tick(1'b1, 1'b0, 1'b0, 1'b0, "R8");

    // random mix: segments of varying pulse density and analog bursts
    begin
      bit a;
      a = 1'b0;
      for (int s = 0; s < 120; s++) begin
        int dens, len;
        bit c;
        dens = $urandom % 5;
        len  = 100 + ($urandom % 400);
        c    = $urandom % 2;
        for (int i = 0; i < len; i++) begin
          bit one;
          case (dens)
            0: one = 1'b0;
            1: one = ($urandom % 2) == 0;
            2: one = ($urandom % 3) != 0;
            3: one = 1'b1;
            default: one = ($urandom % 8) == 0;
          endcase
          if (($urandom % 200) == 0) a = ~a;
          tick(one & ($urandom % 2 == 0), one & ($urandom % 2 == 1) | (one & dens == 3),
               a, c, "R8");
        end
      end
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule